// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a single-cycle register bus with address, write enable, write data and combinational read data. Each counter has three registers. The control register holds the tick-source select, the auto-reload and load-on-write options, the interrupt enable and a sticky interrupt flag. The live count register can only be read. The fixed count register holds the value that is loaded into the counter.

Software programs a delay by writing the number of ticks still to go. The counter steps down on each selected tick. When it reaches zero it raises its flag. Depending on the reload option it then either rests at zero or wraps back to the fixed count and runs on freely. A common setup uses counter 0 for one-shot events and counter 1 as a free-running timestamp.

Every register has a set alias and a clear alias, so single bits can be changed atomically. A global control register provides a one-cycle soft reset. A read-only version register reports major version 2.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every control, count and fixed count register reads 0, the global control at 0x000 reads 0, `irq_o` is low, and the version register at 0x120 reads 0x0200_0000 (major version in bits 31:24).
- R2: Counter n has its control at 0x20+n*0x40, its live count at 0x30+n*0x40 and its fixed count at 0x40+n*0x40. The control fields are: select in bits 3:0, RELOAD in bit 6, UPDATE in bit 7, IRQ_EN in bit 14 and the flag in bit 15. All other control bits read 0. Writes to the live count address have no effect.
- R3: A write at register base +0x4 ORs the data into the register. A write at base +0x8 clears the bits that are set in the data. A write at +0x0 replaces the register.
- R4: The live count drops by one per selected tick. Select 0xF ticks on every clock, and select 0xB ticks on each cycle in which `ref_tick` is high. Any other select value freezes the counter.
- R5: A tick that takes the count from 1 to 0 sets the flag in the following cycle. With RELOAD clear, the count then stays at 0.
- R6: The flag stays set until software writes a 1 to bit 15 through the clear alias, or writes the control register with bit 15 at 0.
- R7: `irq_o` is high exactly when some counter has both its flag and IRQ_EN set. Clearing IRQ_EN keeps the flag.
- R8: With UPDATE set, a write to the fixed count loads the new value into the live count on the same clock edge, and that load overrides a tick. With UPDATE clear, the live count is not changed.
- R9: With RELOAD set, a tick at count 0 loads the fixed count, so the counter repeats every fixed+1 ticks.
- R10: Setting bit 31 of the global control register makes that bit read 1 for one cycle. The following edge clears the bit and every control, count and fixed count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick pulse, used by select 0xB |
| bus_addr | input | 9 | Register byte address |
| bus_we | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and `irq_o` are combinational from the registers. The bench therefore checks them 1 ns after setting the address at a falling edge, with no clock edge in between. A register write takes effect at the single rising edge inside the write task, and the task returns at the next falling edge, which is where the new value is first checked. A load through UPDATE shows in that same sample. The count then changes once per rising edge, so the bench waits a counted number of falling edges before it checks the value. The flag and `irq_o` appear at the sample after the edge on which the count reaches 0. The soft-reset bit is checked one sample after its write, and the cleared registers one edge after that.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int NCNT = 2,
  parameter int CW = 32,
  parameter int AW = 9,
  parameter logic [7:0] MAJOR = 8'd2,
  parameter logic [3:0] REF_SEL = 4'hB,
  parameter logic [3:0] FAST_SEL = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o
);
  localparam logic [AW-1:0] VER_ADDR = AW'(32'h120);
  localparam int STRIDE = 'h40;
  localparam int CTL_OFF = 'h20;
  localparam int CNT_OFF = 'h30;
  localparam int FIX_OFF = 'h40;

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] wd,
                                        input logic [1:0] kind);
    case (kind)
      2'd1:    merge = cur | wd;
      2'd2:    merge = cur & ~wd;
      default: merge = wd;
    endcase
  endfunction

  logic [AW-1:0] blk;
  logic [1:0]    op;
  logic          wr_ok;
  logic          srst_q;
  logic [31:0]   gctl_new;
  logic          unused_top;

  logic [NCNT-1:0]          irq_v, ien_v, rld_v, upd_v;
  logic [NCNT-1:0][3:0]     sel_v;
  logic [NCNT-1:0][CW-1:0]  cnt_v, fix_v;
  logic [NCNT-1:0][31:0]    ctl_rd;

  assign blk      = {bus_addr[AW-1:4], 4'h0};
  assign op       = bus_addr[3:2];
  assign wr_ok    = bus_we && (op != 2'd3);
  assign gctl_new = merge({srst_q, 31'h0}, bus_wdata, op);
  assign unused_top = ^{bus_addr[1:0], gctl_new[30:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     srst_q <= 1'b0;
    else if (srst_q)                                srst_q <= 1'b0;
    else if (wr_ok && blk == '0 && gctl_new[31])    srst_q <= 1'b1;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam logic [AW-1:0] CTL_A = AW'(CTL_OFF + g * STRIDE);
    localparam logic [AW-1:0] FIX_A = AW'(FIX_OFF + g * STRIDE);

    logic          irq_q, ien_q, rld_q, upd_q;
    logic [3:0]    sel_q;
    logic [CW-1:0] cnt_q, fix_q;
    logic          ctl_wr, fix_wr, load, tick, at_one;
    logic [31:0]   ctl_new, fix_new;
    logic          unused_g;

    assign ctl_rd[g] = {16'h0, irq_q, ien_q, 6'h0, upd_q, rld_q, 2'h0, sel_q};
    assign irq_v[g] = irq_q;
    assign ien_v[g] = ien_q;
    assign rld_v[g] = rld_q;
    assign upd_v[g] = upd_q;
    assign sel_v[g] = sel_q;
    assign cnt_v[g] = cnt_q;
    assign fix_v[g] = fix_q;

    assign ctl_wr  = wr_ok && blk == CTL_A;
    assign fix_wr  = wr_ok && blk == FIX_A;
    assign ctl_new = merge(ctl_rd[g], bus_wdata, op);
    assign fix_new = merge(32'(fix_q), bus_wdata, op);
    assign load    = fix_wr && upd_q;
    assign tick    = (sel_q == FAST_SEL) || (sel_q == REF_SEL && ref_tick);
    assign at_one  = tick && !load && cnt_q == CW'(1);
    assign unused_g = ^{ctl_new[31:16], ctl_new[13:8], ctl_new[5:4], fix_new};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        {irq_q, ien_q, rld_q, upd_q} <= '0;
        sel_q <= '0;
        cnt_q <= '0;
        fix_q <= '0;
      end else if (srst_q) begin
        {irq_q, ien_q, rld_q, upd_q} <= '0;
        sel_q <= '0;
        cnt_q <= '0;
        fix_q <= '0;
      end else begin
        if (ctl_wr) begin
          sel_q <= ctl_new[3:0];
          rld_q <= ctl_new[6];
          upd_q <= ctl_new[7];
          ien_q <= ctl_new[14];
        end
        if (at_one)      irq_q <= 1'b1;
        else if (ctl_wr) irq_q <= ctl_new[15];
        if (fix_wr) fix_q <= CW'(fix_new);
        if (load)
          cnt_q <= CW'(fix_new);
        else if (tick) begin
          if (cnt_q == '0) cnt_q <= rld_q ? fix_q : '0;
          else             cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (blk == '0)       bus_rdata = {srst_q, 31'h0};
    if (blk == VER_ADDR) bus_rdata = {MAJOR, 24'h0};
    for (int n = 0; n < NCNT; n++) begin
      if (blk == AW'(CTL_OFF + n * STRIDE)) bus_rdata = ctl_rd[n];
      if (blk == AW'(CNT_OFF + n * STRIDE)) bus_rdata = 32'(cnt_v[n]);
      if (blk == AW'(FIX_OFF + n * STRIDE)) bus_rdata = 32'(fix_v[n]);
    end
  end

  assign irq_o = |(irq_v & ien_v);
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk #(
  parameter int NCNT = 2,
  parameter int CW = 32,
  parameter int AW = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [AW-1:0]           bus_addr,
  input logic                    bus_we,
  input logic                    irq_o,
  input logic                    srst_q,
  input logic [NCNT-1:0]         irq_v,
  input logic [NCNT-1:0]         ien_v,
  input logic [NCNT-1:0]         rld_v,
  input logic [NCNT-1:0][CW-1:0] cnt_v,
  input logic [NCNT-1:0][CW-1:0] fix_v
);
  logic [AW-1:0] blk;
  logic          wr_ok;
  logic          unused_chk;
  assign blk   = {bus_addr[AW-1:4], 4'h0};
  assign wr_ok = bus_we && (bus_addr[3:2] != 2'd3);
  assign unused_chk = ^bus_addr[1:0];

  a_r10_srst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (cnt_v == '0 && fix_v == '0 && irq_v == '0));

  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_v == '0) |-> !irq_o);

  for (genvar g = 0; g < NCNT; g++) begin : g_chk
    logic wctl, wfix;
    assign wctl = wr_ok && blk == AW'(32'h20 + g * 32'h40);
    assign wfix = wr_ok && blk == AW'(32'h40 + g * 32'h40);

    a_r5_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_v[g] == '0 && !rld_v[g] && !wfix && !wctl && !srst_q) |=> cnt_v[g] == '0);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_v[g] && !wctl && !srst_q) |=> irq_v[g]);

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_v[g] != '0 && !wfix && !srst_q) |=>
        (cnt_v[g] == $past(cnt_v[g]) || cnt_v[g] == $past(cnt_v[g]) - CW'(1)));
  end
endmodule

bind dual_down_timer dual_down_timer_chk #(.NCNT(NCNT), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .irq_o(irq_o),
  .srst_q(srst_q), .irq_v(irq_v), .ien_v(ien_v), .rld_v(rld_v),
  .cnt_v(cnt_v), .fix_v(fix_v));

// File: tb/dual_down_timer_tb.sv
`timescale 1ns/1ps
module dual_down_timer_tb;
  localparam int WD_CYC = 200000;
  localparam int NV = 21;
  // {tag, we, addr, data}; for reads, data is the expected value
  localparam logic [45:0] VEC [NV] = '{
    {4'd2, 1'b1, 9'h020, 32'h0000_4080},
    {4'd2, 1'b0, 9'h020, 32'h0000_4080},  // R2
    {4'd8, 1'b1, 9'h040, 32'h0000_1234},
    {4'd8, 1'b0, 9'h030, 32'h0000_1234},  // R8
    {4'd2, 1'b0, 9'h040, 32'h0000_1234},  // R2
    {4'd3, 1'b1, 9'h024, 32'h0000_0040},
    {4'd3, 1'b0, 9'h020, 32'h0000_40C0},  // R3
    {4'd3, 1'b1, 9'h028, 32'h0000_0080},
    {4'd3, 1'b0, 9'h020, 32'h0000_4040},  // R3
    {4'd8, 1'b1, 9'h040, 32'h0000_0055},
    {4'd8, 1'b0, 9'h030, 32'h0000_1234},  // R8
    {4'd8, 1'b0, 9'h040, 32'h0000_0055},  // R8
    {4'd2, 1'b1, 9'h030, 32'h0000_0000},
    {4'd2, 1'b0, 9'h030, 32'h0000_1234},  // R2
    {4'd2, 1'b1, 9'h060, 32'hFFFF_FFFF},
    {4'd2, 1'b0, 9'h060, 32'h0000_C0CF},  // R2
    {4'd3, 1'b1, 9'h068, 32'hFFFF_FFFF},
    {4'd3, 1'b0, 9'h060, 32'h0000_0000},  // R3
    {4'd1, 1'b0, 9'h120, 32'h0200_0000},  // R1
    {4'd3, 1'b1, 9'h044, 32'h0000_0F00},
    {4'd3, 1'b0, 9'h040, 32'h0000_0F55}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    #1;
    total++;
    if (irq_o !== exp) begin
      bad++;
      $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #(WD_CYC * 8);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    rd(9'h020, 32'h0, "R1");
    rd(9'h030, 32'h0, "R1");
    rd(9'h080, 32'h0, "R1");
    rd(9'h000, 32'h0, "R1");
    irq_chk(1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) wr(VEC[i][40:32], VEC[i][31:0]);
      else rd(VEC[i][40:32], VEC[i][31:0], $sformatf("R%0d vec%0d", VEC[i][45:42], i));
    end

    // R4 R5 R8: one-shot on every clock
    do_reset();
    wr(9'h020, 32'h0000_408F);
    wr(9'h040, 32'd5);
    rd(9'h030, 32'd5, "R8");
    step(4);
    rd(9'h030, 32'd1, "R4");
    irq_chk(1'b0, "R5");
    step(1);
    rd(9'h030, 32'd0, "R5");
    irq_chk(1'b1, "R5");
    rd(9'h020, 32'h0000_C08F, "R5");
    step(3);
    rd(9'h030, 32'd0, "R5");

    // R7 mask keeps the flag, R6 clear alias
    wr(9'h028, 32'h0000_4000);
    rd(9'h020, 32'h0000_808F, "R7");
    irq_chk(1'b0, "R7");
    wr(9'h024, 32'h0000_4000);
    irq_chk(1'b1, "R7");
    wr(9'h028, 32'h0000_8000);
    rd(9'h020, 32'h0000_408F, "R6");
    irq_chk(1'b0, "R6");

    // R9 free-running counter 1
    wr(9'h060, 32'h0000_00CF);
    wr(9'h080, 32'd3);
    rd(9'h070, 32'd3, "R9");
    step(2);
    rd(9'h070, 32'd1, "R9");
    step(1);
    rd(9'h070, 32'd0, "R9");
    rd(9'h060, 32'h0000_80CF, "R9");
    irq_chk(1'b0, "R7");
    step(1);
    rd(9'h070, 32'd3, "R9");

    // R4 reference tick and frozen select
    wr(9'h020, 32'h0000_008B);
    wr(9'h040, 32'd10);
    rd(9'h030, 32'd10, "R4");
    step(3);
    rd(9'h030, 32'd10, "R4");
    ref_tick = 1'b1;
    step(1);
    ref_tick = 1'b0;
    rd(9'h030, 32'd9, "R4");
    wr(9'h020, 32'h0000_0083);
    ref_tick = 1'b1;
    step(1);
    ref_tick = 1'b0;
    rd(9'h030, 32'd9, "R4");

    // R10 soft reset
    wr(9'h000, 32'h8000_0000);
    rd(9'h000, 32'h8000_0000, "R10");
    step(1);
    rd(9'h000, 32'h0, "R10");
    rd(9'h060, 32'h0, "R10");
    rd(9'h070, 32'h0, "R10");
    rd(9'h040, 32'h0, "R10");
    rd(9'h020, 32'h0, "R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule